// File: doc/BRIEF.md
# Two-Level Interrupt Poll Arbiter

This block decides, once per machine cycle of a multi-cycle 8-bit core, whether an interrupt vector should be taken and for which source. On every machine-cycle tick it stores the request flags the core has latched. The poll made at the same tick reads the value stored at the tick before. Each source has an enable bit and a priority bit. A global enable gates every vector. A request wins only if its level is not blocked by a service already in progress. The poll only counts when it falls in the last machine cycle of an instruction that is not a postponing one, such as a return-from-interrupt or a write to an enable register.

Every poll stands alone. A request that is denied is not queued. It is taken later only if it is still in the snapshot when the blocking condition ends. The winning source leaves the block on a valid/ready vector channel. When the core accepts the vector, the block pulses that source's acknowledge and marks the level as in service. A return pulse from the core clears the highest in-service level.

Top module: `irq_poll_arbiter`

## Requirements
- R1: Each `cyc_tick` stores `req_flags` into a snapshot, and the poll at that tick reads the snapshot stored at the previous tick. A flag that is present only at the polling tick does not take part in that poll.
- R2: A vector is raised only by a poll at a tick where `instr_last`=1, `block_instr`=0 and `glob_en`=1.
- R3: A denied request leaves no trace. It is granted at a later poll only if its flag is in that poll's snapshot.
- R4: A source whose `src_en` bit is 0 is never granted, even when its flag is set.
- R5: A source with `src_hi`=1 beats every source with `src_hi`=0. Within one level, the lowest source index wins.
- R6: A low-level request is refused while either level is in service. A high-level request is refused while the high level is in service.
- R7: Once raised, `vec_valid` and `vec_idx` hold steady until `vec_ready` is seen. No new poll is taken while a vector is pending.
- R8: In the clock after a handshake (`vec_valid`=1 and `vec_ready`=1), bit `vec_idx` of `src_ack` is high for exactly one clock. At the same edge, the granted level's in-service flag (`srv_hi` or `srv_lo`) is set.
- R9: A `reti_pulse` clears `srv_hi` if it is set, and otherwise clears `srv_lo`.
- R10: After reset, `vec_valid`, `src_ack`, `srv_hi` and `srv_lo` are all 0, and the snapshot is empty.

The vector channel follows these back-pressure rules. The block may hold `vec_valid` for any number of clocks. The core takes the vector at the first clock edge where `vec_valid` and `vec_ready` are both high. `vec_ready` has no effect while `vec_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_tick | input | 1 | One-clock strobe marking a machine-cycle poll point |
| req_flags | input | N_SRC | Request flags latched by the core |
| src_en | input | N_SRC | Enable bit for each source |
| src_hi | input | N_SRC | Priority bit for each source (1 = high level) |
| glob_en | input | 1 | Global interrupt enable |
| instr_last | input | 1 | The current machine cycle is the last one of the instruction |
| block_instr | input | 1 | A postponing instruction is executing |
| reti_pulse | input | 1 | Return-from-interrupt pulse |
| vec_valid | output | 1 | A vector request is pending |
| vec_ready | input | 1 | The core accepts the vector |
| vec_idx | output | IDX_W | Index of the granted source |
| src_ack | output | N_SRC | One-clock acknowledge for the granted source |
| srv_hi | output | 1 | The high level is in service |
| srv_lo | output | 1 | The low level is in service |

## Verification
The bench targets a request that shows up at a blocked poll and is gone by the next one. A design that queued denied requests would raise a vector the bench does not expect. A flag that arrives only at the polling tick must not be granted, which catches a design that polls live flags instead of the previous snapshot. The bench also checks that a high-level request preempts a low-level service but not another high-level service, and that a vector held under back-pressure keeps its index while a new poll arrives. The last case would expose a design that kept polling and overwrote the pending vector. Finally, a return pulse with both levels in service must clear only the high level.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic {
    LVL_LO = 1'b0,
    LVL_HI = 1'b1
  } irq_lvl_e;
endpackage

// File: rtl/irq_flag_sampler.sv
module irq_flag_sampler #(
  parameter int N_SRC = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_tick,
  input  logic [N_SRC-1:0] flags_in,
  output logic [N_SRC-1:0] snap_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        snap_q <= '0;
    else if (cyc_tick) snap_q <= flags_in;
  end

  AST_SNAP_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_tick |=> $stable(snap_q)); // R1
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N_SRC = 6,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] cand,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (cand[i]) idx = IDX_W'(i);
    end
  end
  assign any = |cand;

  always_comb begin
    if (any) AST_PICK_IS_SET: assert (cand[idx]); // R5
  end
endmodule

// File: rtl/irq_level_tracker.sv
module irq_level_tracker (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  irq_pkg::irq_lvl_e set_lvl,
  input  logic             ret_pulse,
  output logic             hi_q,
  output logic             lo_q
);
  import irq_pkg::*;

  logic hi_d, lo_d;

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    if (ret_pulse) begin
      if (hi_q) hi_d = 1'b0;
      else      lo_d = 1'b0;
    end
    if (set_en) begin
      if (set_lvl == LVL_HI) hi_d = 1'b1;
      else                   lo_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  AST_RET_CLEARS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    ret_pulse && hi_q && !set_en |=> !hi_q); // R9
  AST_RET_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    ret_pulse && hi_q && lo_q |=> lo_q); // R9
endmodule

// File: rtl/irq_poll_arbiter.sv
module irq_poll_arbiter #(
  parameter int N_SRC = 6,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_tick,
  input  logic [N_SRC-1:0] req_flags,
  input  logic [N_SRC-1:0] src_en,
  input  logic [N_SRC-1:0] src_hi,
  input  logic             glob_en,
  input  logic             instr_last,
  input  logic             block_instr,
  input  logic             reti_pulse,
  output logic             vec_valid,
  input  logic             vec_ready,
  output logic [IDX_W-1:0] vec_idx,
  output logic [N_SRC-1:0] src_ack,
  output logic             srv_hi,
  output logic             srv_lo
);
  import irq_pkg::*;

  logic [N_SRC-1:0] snap;
  logic [N_SRC-1:0] cand_hi, cand_lo;
  logic             any_hi, any_lo;
  logic [IDX_W-1:0] idx_hi, idx_lo;
  logic             poll_fire, take_hi, take_lo, hs;
  logic             vec_valid_q;
  logic [IDX_W-1:0] vec_idx_q;
  irq_lvl_e         vec_lvl_q;
  logic [N_SRC-1:0] ack_q;

  irq_flag_sampler #(.N_SRC(N_SRC)) u_sampler (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick),
    .flags_in(req_flags), .snap_q(snap)
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_mask
    assign cand_hi[g] = snap[g] & src_en[g] &  src_hi[g];
    assign cand_lo[g] = snap[g] & src_en[g] & ~src_hi[g];
  end

  irq_prio_pick #(.N_SRC(N_SRC)) u_pick_hi (.cand(cand_hi), .any(any_hi), .idx(idx_hi));
  irq_prio_pick #(.N_SRC(N_SRC)) u_pick_lo (.cand(cand_lo), .any(any_lo), .idx(idx_lo));

  assign poll_fire = cyc_tick && instr_last && !block_instr && glob_en && !vec_valid_q;
  assign take_hi   = poll_fire && !srv_hi && any_hi;
  assign take_lo   = poll_fire && !take_hi && !srv_hi && !srv_lo && any_lo;
  assign hs        = vec_valid_q && vec_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_valid_q <= 1'b0;
      vec_idx_q   <= '0;
      vec_lvl_q   <= LVL_LO;
    end else if (take_hi) begin
      vec_valid_q <= 1'b1;
      vec_idx_q   <= idx_hi;
      vec_lvl_q   <= LVL_HI;
    end else if (take_lo) begin
      vec_valid_q <= 1'b1;
      vec_idx_q   <= idx_lo;
      vec_lvl_q   <= LVL_LO;
    end else if (hs) begin
      vec_valid_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_ack
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ack_q[g] <= 1'b0;
      else        ack_q[g] <= hs && (vec_idx_q == IDX_W'(g));
    end
  end

  irq_level_tracker u_track (
    .clk(clk), .rst_n(rst_n), .set_en(hs), .set_lvl(vec_lvl_q),
    .ret_pulse(reti_pulse), .hi_q(srv_hi), .lo_q(srv_lo)
  );

  assign vec_valid = vec_valid_q;
  assign vec_idx   = vec_idx_q;
  assign src_ack   = ack_q;

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_ack)); // R8
  AST_ACK_AFTER_HS: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && vec_ready |=> $countones(src_ack) == 1); // R8
  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && !vec_ready |=> vec_valid && $stable(vec_idx)); // R7
  AST_RAISE_NEEDS_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid) |-> $past(cyc_tick && instr_last && !block_instr && glob_en)); // R2
  AST_HI_NOT_PREEMPTED: assert property (@(posedge clk) disable iff (!rst_n)
    srv_hi |-> !vec_valid); // R6
  AST_LO_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && vec_lvl_q == LVL_LO |-> !srv_hi && !srv_lo); // R6
endmodule

// File: tb/irq_poll_arbiter_tb_top.sv
module irq_poll_arbiter_tb_top;
  localparam int N = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cyc_tick = 0, glob_en = 0, instr_last = 0, block_instr = 0;
  logic reti_pulse = 0, vec_ready = 0;
  logic [N-1:0] req_flags = '0, src_en = '0, src_hi = '0;
  logic vec_valid, srv_hi, srv_lo;
  logic [2:0] vec_idx;
  logic [N-1:0] src_ack;
  int errs = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_poll_arbiter #(.N_SRC(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .req_flags(req_flags),
    .src_en(src_en), .src_hi(src_hi), .glob_en(glob_en), .instr_last(instr_last),
    .block_instr(block_instr), .reti_pulse(reti_pulse), .vec_valid(vec_valid),
    .vec_ready(vec_ready), .vec_idx(vec_idx), .src_ack(src_ack),
    .srv_hi(srv_hi), .srv_lo(srv_lo)
  );

  // fields: flags[24:19] en[18:13] hi[12:7] glob[6] last[5] blk[4] expv[3] idx[2:0]
  localparam logic [24:0] VEC [9] = '{
    {6'b000001, 6'b111111, 6'b000000, 1'b1, 1'b1, 1'b0, 1'b1, 3'd0}, // R5
    {6'b001100, 6'b111111, 6'b001000, 1'b1, 1'b1, 1'b0, 1'b1, 3'd3}, // R5 hi beats lower idx
    {6'b110000, 6'b100000, 6'b000000, 1'b1, 1'b1, 1'b0, 1'b1, 3'd5}, // R4
    {6'b000001, 6'b111111, 6'b000000, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0}, // R2 glob off
    {6'b000001, 6'b111111, 6'b000000, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0}, // R2 not last
    {6'b000001, 6'b111111, 6'b000000, 1'b1, 1'b1, 1'b1, 1'b0, 3'd0}, // R2 blocked
    {6'b000110, 6'b111111, 6'b000110, 1'b1, 1'b1, 1'b0, 1'b1, 3'd1}, // R5 tie
    {6'b000000, 6'b111111, 6'b111111, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0}, // R1 none
    {6'b111111, 6'b000000, 6'b010101, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0}  // R4 all masked
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic mc(input logic [N-1:0] f, input logic last, input logic blk);
    @(negedge clk);
    req_flags = f; instr_last = last; block_instr = blk; cyc_tick = 1'b1;
    @(negedge clk);
    cyc_tick = 1'b0; instr_last = 1'b0; block_instr = 1'b0;
  endtask

  task automatic accept(input int idx, input string req);
    @(negedge clk) vec_ready = 1'b1;
    @(negedge clk) vec_ready = 1'b0;
    chk(src_ack == N'(1 << idx), req, int'(src_ack), 1 << idx);
    @(negedge clk);
    chk(src_ack == '0, req, int'(src_ack), 0);
  endtask

  task automatic ret();
    @(negedge clk) reti_pulse = 1'b1;
    @(negedge clk) reti_pulse = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(vec_valid == 0 && src_ack == 0, "R10", int'(vec_valid), 0);
    chk(srv_hi == 0 && srv_lo == 0, "R10", int'({srv_hi, srv_lo}), 0);
    rst_n = 1'b1;

    foreach (VEC[k]) begin
      src_en = VEC[k][18:13]; src_hi = VEC[k][12:7]; glob_en = VEC[k][6];
      mc(VEC[k][24:19], 1'b0, 1'b0);
      mc('0, VEC[k][5], VEC[k][4]);
      chk(vec_valid == VEC[k][3], "R2/R4/R5 valid", int'(vec_valid), int'(VEC[k][3]));
      if (VEC[k][3]) begin
        chk(vec_idx == VEC[k][2:0], "R5 idx", int'(vec_idx), int'(VEC[k][2:0]));
        accept(int'(VEC[k][2:0]), "R8");
        chk((VEC[k][12:7] >> VEC[k][2:0]) & 1 ? srv_hi : srv_lo, "R8 level", 0, 1);
        ret();
      end
    end

    src_en = '1; src_hi = '0; glob_en = 1'b1;
    // R1: flag present only at the polling tick is not seen
    mc('0, 1'b0, 1'b0);
    mc(6'b000100, 1'b1, 1'b0);
    chk(!vec_valid, "R1 live flag ignored", int'(vec_valid), 0);
    mc('0, 1'b1, 1'b0); // R1 now the stored flag is polled
    chk(vec_valid && vec_idx == 2, "R1 stored flag", int'(vec_idx), 2);
    accept(2, "R8"); ret();

    // R3: blocked request that goes away is lost
    mc(6'b000100, 1'b0, 1'b0);
    mc('0, 1'b1, 1'b1);
    mc('0, 1'b1, 1'b0);
    chk(!vec_valid, "R3 lost", int'(vec_valid), 0);
    // R3: postponed request still present is taken
    mc(6'b000100, 1'b0, 1'b0);
    mc(6'b000100, 1'b1, 1'b1);
    chk(!vec_valid, "R3 postponed", int'(vec_valid), 0);
    mc('0, 1'b1, 1'b0);
    chk(vec_valid && vec_idx == 2, "R3 retaken", int'(vec_idx), 2);
    accept(2, "R8"); ret();

    // R6 preemption: low in service
    src_hi = 6'b011000;
    mc(6'b000001, 1'b0, 1'b0); mc('0, 1'b1, 1'b0);
    accept(0, "R8");
    chk(srv_lo && !srv_hi, "R8 lo set", int'({srv_hi, srv_lo}), 1);
    mc(6'b000010, 1'b0, 1'b0); mc('0, 1'b1, 1'b0);
    chk(!vec_valid, "R6 lo blocks lo", int'(vec_valid), 0);
    mc(6'b010000, 1'b0, 1'b0); mc('0, 1'b1, 1'b0);
    chk(vec_valid && vec_idx == 4, "R6 hi preempts lo", int'(vec_idx), 4);
    accept(4, "R8");
    chk(srv_hi && srv_lo, "R8 both set", int'({srv_hi, srv_lo}), 3);
    mc(6'b001000, 1'b0, 1'b0); mc('0, 1'b1, 1'b0);
    chk(!vec_valid, "R6 hi blocks hi", int'(vec_valid), 0);
    ret();
    chk(!srv_hi && srv_lo, "R9 clear hi first", int'({srv_hi, srv_lo}), 1);
    ret();
    chk(!srv_hi && !srv_lo, "R9 clear lo", int'({srv_hi, srv_lo}), 0);

    // R7 back-pressure
    mc(6'b000010, 1'b0, 1'b0); mc('0, 1'b1, 1'b0);
    mc(6'b001000, 1'b0, 1'b0); mc('0, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    chk(vec_valid && vec_idx == 1, "R7 held", int'(vec_idx), 1);
    accept(1, "R8");
    chk(!vec_valid, "R7 released", int'(vec_valid), 0);
    ret();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule